// File: doc/BRIEF.md
# DMA Stream Interrupt Flag Bank

This block holds the interrupt status flags for an eight-stream DMA controller. Each stream has five event inputs: FIFO error, direct-mode error, transfer error, half transfer and transfer complete. A one-cycle pulse on an event input sets a matching sticky flag. Software sees the flags through two packed status words and clears them by writing ones into two separate clear words.

Every stream has its own interrupt line. The line is high while any of the stream's flags is set and that flag's enable bit is also set. The register port is a plain word-addressed read/write interface. Read data is combinational from the word address. Writes take effect at the clock edge.

Top module: `dma_irq_flag_bank`

## Requirements
- R1: After reset every flag is clear, every interrupt line is low, and all four words read as zero.
- R2: A one-cycle pulse on an event input sets that stream's flag at the next clock edge. Streams 0-3 appear in the status word at word address 0 (byte 0x00), and streams 4-7 appear in the status word at word address 1 (byte 0x04). Within its word, stream s starts its group at bit ((s mod 4 & 2) << 3) | ((s mod 4 & 1) * 6), which gives 0, 6, 16 and 22. Within a group, FIFO error sits at bit 0, direct-mode error at bit 2, transfer error at bit 3, half transfer at bit 4 and transfer complete at bit 5.
- R3: A flag stays set over any number of cycles until it is cleared.
- R4: Writing to word address 2 (byte 0x08) clears each flag of streams 0-3 whose bit position is written as one. Word address 3 (byte 0x0C) does the same for streams 4-7, using the layout of R2. Flags whose bits are written as zero are kept.
- R5: When an event and a clear reach the same flag in the same cycle, the flag ends up set. Other flags of the same stream that are cleared in that cycle still clear.
- R6: Interrupt line s is the OR, over the stream's five flags, of each flag ANDed with its enable bit. The stream's 5-bit enable field is irq_en[5s+4:5s], laid out as bit 0 FIFO error, bit 1 direct-mode error, bit 2 transfer error, bit 3 half transfer and bit 4 transfer complete. A change of enable shows on the line in the same cycle.
- R7: In the status words, the reserved bit 1 of each group and bits 12-15 and 28-31 read as zero. Writes to word addresses 0 and 1 change no flag.
- R8: Both clear words always read as zero.
- R9: A write to one clear word leaves the flags of the other four streams unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_fifo_err | input | 8 | FIFO error event pulse, one bit per stream |
| evt_dm_err | input | 8 | Direct-mode error event pulse, one bit per stream |
| evt_xfer_err | input | 8 | Transfer error event pulse, one bit per stream |
| evt_half | input | 8 | Half transfer event pulse, one bit per stream |
| evt_done | input | 8 | Transfer complete event pulse, one bit per stream |
| irq_en | input | 40 | Per-stream 5-bit interrupt enable fields |
| bus_word | input | 2 | Word address: 0 status low, 1 status high, 2 clear low, 3 clear high |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word |
| irq | output | 8 | Per-stream interrupt lines |

## Verification
An event pulse and a write-one-to-clear can reach the same flag in one cycle. The bench drives both together on one stream. In that same cycle it also clears a second flag of that stream that has no event. The next status read must show the event flag set and the other flag cleared. The scoreboard model applies the clear first and the set second, so a design where the clear takes priority shows up as a miscompare.

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
  parameter int NSTREAM = 8,
  parameter int NEVT    = 5,
  parameter int DW      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSTREAM-1:0]      evt_fifo_err,
  input  logic [NSTREAM-1:0]      evt_dm_err,
  input  logic [NSTREAM-1:0]      evt_xfer_err,
  input  logic [NSTREAM-1:0]      evt_half,
  input  logic [NSTREAM-1:0]      evt_done,
  input  logic [NSTREAM*NEVT-1:0] irq_en,
  input  logic [1:0]              bus_word,
  input  logic                    bus_we,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  output logic [NSTREAM-1:0]      irq
);
  localparam int HALF = NSTREAM / 2;
  localparam int NF   = NSTREAM * NEVT;

  function automatic int grp_off(int s);
    return ((s & 2) << 3) | ((s & 1) * 6);
  endfunction

  function automatic int evt_pos(int k);
    return (k == 0) ? 0 : k + 1;
  endfunction

  function automatic logic [DW-1:0] live_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < HALF; s++)
      for (int k = 0; k < NEVT; k++)
        m[grp_off(s) + evt_pos(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] LIVE = live_mask();

  logic [NF-1:0] evt_flat;
  logic [NF-1:0] flg;
  logic [DW-1:0] wclr;
  logic [DW-1:0] img_lo, img_hi;

  assign wclr = bus_wdata & LIVE;

  for (genvar s = 0; s < NSTREAM; s++) begin : g_strm
    assign evt_flat[s*NEVT +: NEVT] =
      {evt_done[s], evt_half[s], evt_xfer_err[s], evt_dm_err[s], evt_fifo_err[s]};
    assign irq[s] = |(flg[s*NEVT +: NEVT] & irq_en[s*NEVT +: NEVT]);

    for (genvar k = 0; k < NEVT; k++) begin : g_flag
      localparam int H = s / HALF;
      localparam int B = grp_off(s % HALF) + evt_pos(k);
      logic hit;
      assign hit = bus_we && (bus_word == 2'(2 + H)) && wclr[B];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   flg[s*NEVT+k] <= 1'b0;
        else if (evt_flat[s*NEVT+k])  flg[s*NEVT+k] <= 1'b1;
        else if (hit)                 flg[s*NEVT+k] <= 1'b0;
      end
    end
  end

  always_comb begin
    img_lo = '0;
    img_hi = '0;
    for (int s = 0; s < NSTREAM; s++)
      for (int k = 0; k < NEVT; k++)
        if (s < HALF) img_lo[grp_off(s) + evt_pos(k)] = flg[s*NEVT+k];
        else          img_hi[grp_off(s - HALF) + evt_pos(k)] = flg[s*NEVT+k];
  end

  always_comb begin
    case (bus_word)
      2'd0:    bus_rdata = img_lo;
      2'd1:    bus_rdata = img_hi;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module dma_irq_flag_bank_chk #(
  parameter int NSTREAM = 8,
  parameter int NEVT    = 5,
  parameter int DW      = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSTREAM-1:0]      evt_fifo_err,
  input logic [NSTREAM-1:0]      evt_dm_err,
  input logic [NSTREAM-1:0]      evt_xfer_err,
  input logic [NSTREAM-1:0]      evt_half,
  input logic [NSTREAM-1:0]      evt_done,
  input logic [NSTREAM*NEVT-1:0] irq_en,
  input logic [1:0]              bus_word,
  input logic                    bus_we,
  input logic [DW-1:0]           bus_wdata,
  input logic [DW-1:0]           bus_rdata,
  input logic [NSTREAM-1:0]      irq,
  input logic [NSTREAM*NEVT-1:0] flg
);
  localparam int HALF = NSTREAM / 2;
  localparam int NF   = NSTREAM * NEVT;

  function automatic int c_off(int s);
    int t[4] = '{0, 6, 16, 22};
    return t[s];
  endfunction

  function automatic int c_pos(int k);
    int t[5] = '{0, 2, 3, 4, 5};
    return t[k];
  endfunction

  function automatic logic [DW-1:0] c_live();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < HALF; s++)
      for (int k = 0; k < NEVT; k++)
        m[c_off(s) + c_pos(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] CLIVE = c_live();

  logic [NF-1:0] ev, cm;
  always_comb begin
    for (int s = 0; s < NSTREAM; s++) begin
      ev[s*NEVT+0] = evt_fifo_err[s];
      ev[s*NEVT+1] = evt_dm_err[s];
      ev[s*NEVT+2] = evt_xfer_err[s];
      ev[s*NEVT+3] = evt_half[s];
      ev[s*NEVT+4] = evt_done[s];
      for (int k = 0; k < NEVT; k++)
        cm[s*NEVT+k] = bus_we && bus_word[1] && (bus_word[0] == (s >= HALF))
                       && bus_wdata[c_off(s % HALF) + c_pos(k)];
    end
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flg & $past(ev)) == $past(ev)));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & cm) != '0) |=> ((flg & $past(ev & cm)) == $past(ev & cm)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flg ^ $past(flg)) & ~($past(ev) | $past(cm))) == '0));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cm != '0) |=> ((flg & $past(cm & ~ev)) == '0));

  assert_status_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_word[1] |-> ((bus_rdata & ~CLIVE) == '0));

  assert_clr_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_word[1] |-> (bus_rdata == '0));

  for (genvar s = 0; s < NSTREAM; s++) begin : g_irq
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev[s*NEVT +: NEVT] & irq_en[s*NEVT +: NEVT]) != '0) |=>
      (irq[s] || (irq_en[s*NEVT +: NEVT] != $past(irq_en[s*NEVT +: NEVT]))));
  end
endmodule

bind dma_irq_flag_bank dma_irq_flag_bank_chk #(
  .NSTREAM(NSTREAM), .NEVT(NEVT), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .evt_fifo_err(evt_fifo_err), .evt_dm_err(evt_dm_err), .evt_xfer_err(evt_xfer_err),
  .evt_half(evt_half), .evt_done(evt_done), .irq_en(irq_en),
  .bus_word(bus_word), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .flg(flg)
);

// File: tb/sim_dma_irq_flag_bank.sv
module sim_dma_irq_flag_bank;
  timeunit 1ns; timeprecision 1ps;
  localparam int NS = 8, NK = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  e_fe = '0, e_dm = '0, e_te = '0, e_ht = '0, e_tc = '0;
  logic [39:0] ien = '0;
  logic [1:0]  word = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire  [7:0]  irq;

  dma_irq_flag_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_fifo_err(e_fe), .evt_dm_err(e_dm), .evt_xfer_err(e_te),
    .evt_half(e_ht), .evt_done(e_tc), .irq_en(ien),
    .bus_word(word), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit mdl [NS][NK];

  function automatic int goff(int s);
    int t[4] = '{0, 6, 16, 22};
    return t[s % 4];
  endfunction

  function automatic int kbit(int k);
    int t[5] = '{0, 2, 3, 4, 5};
    return t[k];
  endfunction

  function automatic logic [31:0] image(int h);
    logic [31:0] v = '0;
    for (int s = h*4; s < h*4 + 4; s++)
      for (int k = 0; k < NK; k++)
        if (mdl[s][k]) v[goff(s) + kbit(k)] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] irq_model();
    logic [31:0] v = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NK; k++)
        if (mdl[s][k] && ien[s*5+k]) v[s] = 1'b1;
    return v;
  endfunction

  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      act = (it.kind == 0) ? rdata : {24'b0, irq};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic set_evt(int s, int k, logic v);
    case (k)
      0: e_fe[s] = v;
      1: e_dm[s] = v;
      2: e_te[s] = v;
      3: e_ht[s] = v;
      default: e_tc[s] = v;
    endcase
  endtask

  task automatic fire(int s, int k);
    set_evt(s, k, 1'b1); mdl[s][k] = 1'b1;
    step();
    set_evt(s, k, 1'b0);
  endtask

  task automatic model_clear(int h, logic [31:0] d);
    for (int s = h*4; s < h*4 + 4; s++)
      for (int k = 0; k < NK; k++)
        if (d[goff(s) + kbit(k)]) mdl[s][k] = 1'b0;
  endtask

  task automatic wr(logic [1:0] w, logic [31:0] d);
    we = 1'b1; word = w; wdata = d;
    if (w[1]) model_clear(int'(w[0]), d);
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] w, logic [31:0] exp, string tag);
    item_t it;
    word = w;
    it.kind = 0; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    step();
  endtask

  task automatic chk_irq(string tag);
    item_t it;
    it.kind = 1; it.exp = irq_model(); it.tag = tag;
    sbq.push_back(it);
    step();
  endtask

  task automatic finish_up();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int k = 0; k < NK; k++) mdl[s][k] = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int w = 0; w < 4; w++) rd(2'(w), 32'h0, "R1 reset read");
    chk_irq("R1 reset irq");

    // R2 / R4 every flag placement, then its clear
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NK; k++) begin
        fire(s, k);
        rd(2'(s / 4), image(s / 4), "R2 flag placement");
        wr(2'(2 + s / 4), 32'(1) << (goff(s) + kbit(k)));
        rd(2'(s / 4), image(s / 4), "R4 clear one flag");
      end

    // R3 sticky
    fire(5, 2);
    repeat (6) step();
    rd(2'd1, image(1), "R3 flag held");
    wr(2'd3, 32'h0);
    rd(2'd1, image(1), "R4 zero write keeps flag");

    // R9 halves are independent
    fire(2, 3); fire(6, 3);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, image(0), "R9 low clear empties low");
    rd(2'd1, image(1), "R9 low clear spares high");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, image(1), "R9 high clear");

    // R5 event and clear in the same cycle
    fire(1, 0);
    e_tc[1] = 1'b1; we = 1'b1; word = 2'd2;
    wdata = (32'(1) << (goff(1) + kbit(4))) | (32'(1) << (goff(1) + kbit(0)));
    model_clear(0, wdata);
    mdl[1][4] = 1'b1;
    step();
    e_tc[1] = 1'b0; we = 1'b0; wdata = '0;
    rd(2'd0, image(0), "R5 event beats clear");
    rd(2'd0, 32'h0000_0800, "R5 literal layout");

    // R6 interrupt combine
    fire(4, 1); fire(7, 0);
    chk_irq("R6 flags without enable");
    ien[4*5+3] = 1'b1;
    chk_irq("R6 non-matching enable");
    ien[4*5+1] = 1'b1;
    chk_irq("R6 matching enable");
    ien[7*5+0] = 1'b1;
    chk_irq("R6 fifo enable bit0");
    wr(2'd3, 32'(1) << (goff(4) + kbit(1)));
    chk_irq("R6 cleared flag drops line");
    ien = '0;
    chk_irq("R6 enables off");

    // R7 status writes ignored, reserved bits zero
    fire(0, 4); fire(3, 3);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, image(0), "R7 status write ignored low");
    rd(2'd1, image(1), "R7 status write ignored high");
    for (int s = 0; s < 4; s++) for (int k = 0; k < NK; k++) fire(s, k);
    rd(2'd0, 32'h0F7D_0F7D, "R7 all flags, reserved zero");

    // R8 clear words read zero
    rd(2'd2, 32'h0, "R8 clear low reads zero");
    rd(2'd3, 32'h0, "R8 clear high reads zero");

    step();
    done = 1;
    finish_up();
  end
endmodule